// File: doc/BRIEF.md
# Four-Channel Double-Buffered Serial Converter Front End

This block is the digital front end of a four-channel 8-bit digital-to-analog converter. A host writes 12-bit command words over a three-wire serial link (active-low select, serial clock, serial data). Each word holds two active-low power-down bits, a 2-bit channel address and an 8-bit code. The code lands in a staging register for the addressed channel when select returns high. A level-sensitive, active-low load input copies all four staging registers into the output code registers in the same cycle. The host can therefore stage new codes on every channel and then update them together.

An active-low clear zeroes both register ranks and holds them at zero while it stays low. Reset also brings every register to zero scale. Each channel has a power-down indicator. It is set by the command word (all channels, or the addressed one only) or by a separate active-low external power-down request. All pins are sampled by a fast system clock through synchronizers, and every output is registered.

Top module: `qdac_front`

## Requirements
- R1: After reset every output code is 0x00 and every power-down indicator is 0 (with the external request inactive).
- R2: A command word is 12 bits and is shifted in MSB first on rising serial-clock edges while select is low. Bit 11 is power-down-all (active low), bit 10 is power-down-addressed (active low), bits 9:8 are the channel address, and bits 7:0 are the code.
- R3: Serial-clock edges while select is high leave the shift register unchanged.
- R4: On the rising edge of select, the code is written into the staging register chosen by the address (0 to channel 0, 1 to 1, 2 to 2, 3 to 3). The other channels are unchanged. Channel n's code appears on `dac_codes[8n+7:8n]`.
- R5: While load is high, output codes hold their value regardless of staging writes. A low load copies all four staging registers into the output codes.
- R6: While load is held low, the output codes follow every staging write.
- R7: While clear is low, both register ranks read 0x00 and a completed command word is ignored, including its power-down bits.
- R8: A word with bit 11 low sets every power-down indicator.
- R9: A word with bit 11 high and bit 10 low sets only the indicator of the addressed channel (`chan_off[n]` for channel n).
- R10: A word with bits 11 and 10 both high clears the global power-down and the addressed channel's power-down.
- R11: While the external request is low, every indicator reads 1. On release, the indicators return to the stored power-down state.
- R12: If select rises after more or fewer than 12 serial clocks, the last 12 bits shifted in form the word.
- R13: Clear takes priority over load. Load low during clear leaves codes at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_din | input | 1 | Serial data |
| load_n | input | 1 | Level-sensitive load of output codes, active low |
| clear_n | input | 1 | Clear of both register ranks, active low |
| shdn_req_n | input | 1 | External power-down request, active low |
| dac_codes | output | 32 | Four output codes, channel n at bits 8n+7:8n |
| chan_off | output | 4 | Per-channel power-down indicators |

## Verification
The bench sends directed words that separate each address and each combination of the two power-down bits. A word sent with load held high tells staging writes apart from output updates, and the same word with load held low shows the transparent path. Serial clocks sent while select is high, with a garbage word, are followed by a select pulse with no clocks. This shows whether those clocks moved the shift register. Random words with random prefix lengths, load modes and occasional clear pulses are checked against a bench model of the shift register and both ranks, which tests the last-12-bits rule and the priority of clear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Power-down action taken when a command word is latched
  typedef enum logic [1:0] {
    SD_RESUME = 2'b00,  // both bits high: wake addressed channel and global
    SD_ONE    = 2'b01,  // addressed channel only
    SD_ALL    = 2'b10,  // every channel
    SD_BOTH   = 2'b11   // global and addressed channel
  } sd_act_t;

  localparam int unsigned CTRL_BITS = 2;

  function automatic sd_act_t sd_decode(input logic all_n, input logic one_n);
    case ({all_n, one_n})
      2'b11:   return SD_RESUME;
      2'b10:   return SD_ONE;
      2'b01:   return SD_ALL;
      default: return SD_BOTH;
    endcase
  endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= RST_VAL;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_frame_shifter.sv
module qdac_frame_shifter #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_clk,
  input  logic              s_cs_n,
  input  logic              s_din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CODE_W-1:0] wr_data,
  output logic              sd_all_n,
  output logic              sd_one_n
);

  localparam int unsigned FRAME_W = qdac_pkg::CTRL_BITS + ADDR_W + CODE_W;

  logic               clk_d;
  logic               cs_d;
  logic [FRAME_W-1:0] sr;
  logic               sclk_rise;
  logic               shift_en;
  logic               cs_rise;

  assign sclk_rise = s_clk & ~clk_d;
  assign shift_en  = sclk_rise & ~s_cs_n;
  assign cs_rise   = s_cs_n & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d    <= 1'b0;
      cs_d     <= 1'b1;
      sr       <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sd_all_n <= 1'b1;
      sd_one_n <= 1'b1;
    end else begin
      clk_d <= s_clk;
      cs_d  <= s_cs_n;
      if (shift_en) sr <= {sr[FRAME_W-2:0], s_din};
      wr_en <= cs_rise;
      if (cs_rise) begin
        sd_all_n <= sr[FRAME_W-1];
        sd_one_n <= sr[FRAME_W-2];
        wr_addr  <= sr[CODE_W +: ADDR_W];
        wr_data  <= sr[CODE_W-1:0];
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s_cs_n |=> $stable(sr));

  // R2
  frame_take_chk: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (wr_en && wr_data == $past(sr[CODE_W-1:0])));

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_n,
  input  logic                     load_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [CH_NUM*CODE_W-1:0] dac_flat
);

  logic [CODE_W-1:0] in_q  [CH_NUM];
  logic [CODE_W-1:0] dac_q [CH_NUM];

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst || !clear_n) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end else begin
        if (hit)     in_q[i]  <= wr_data;
        if (!load_n) dac_q[i] <= in_q[i];
      end
    end

    assign dac_flat[i*CODE_W +: CODE_W] = dac_q[i];

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !clear_n |=> (in_q[i] == '0 && dac_q[i] == '0));

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && !load_n) |=> dac_q[i] == $past(in_q[i]));

    // R5
    dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && load_n) |=> $stable(dac_q[i]));

    // R4
    other_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (clear_n && !(wr_en && wr_addr == ADDR_W'(i))) |=> $stable(in_q[i]));
  end

endmodule

// File: rtl/qdac_shdn_ctrl.sv
module qdac_shdn_ctrl #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              sd_all_n,
  input  logic              sd_one_n,
  input  logic              ext_n,
  output logic [CH_NUM-1:0] chan_off
);

  import qdac_pkg::*;

  logic              glob_off;
  logic [CH_NUM-1:0] ch_off;
  sd_act_t           act;

  assign act = sd_decode(sd_all_n, sd_one_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_off <= 1'b0;
      ch_off   <= '0;
    end else if (wr_en) begin
      case (act)
        SD_RESUME: begin glob_off <= 1'b0; ch_off[wr_addr] <= 1'b0; end
        SD_ONE:    ch_off[wr_addr] <= 1'b1;
        SD_ALL:    glob_off <= 1'b1;
        default:   begin glob_off <= 1'b1; ch_off[wr_addr] <= 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chan_off <= '0;
    else     chan_off <= {CH_NUM{glob_off | ~ext_n}} | ch_off;
  end

  // R11
  ext_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_n |=> (&chan_off));

  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sd_all_n) |=> ##1 (&chan_off));

endmodule

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int unsigned CH_NUM      = 4,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_cs_n,
  input  logic                     ser_din,
  input  logic                     load_n,
  input  logic                     clear_n,
  input  logic                     shdn_req_n,
  output logic [CH_NUM*CODE_W-1:0] dac_codes,
  output logic [CH_NUM-1:0]        chan_off
);

  localparam int unsigned ADDR_W = $clog2(CH_NUM);
  localparam int unsigned PIN_W  = 6;
  // idle levels: power-down req, load, clear high; din low; select high; clock low
  localparam logic [PIN_W-1:0] PIN_IDLE = 6'b111010;

  logic [PIN_W-1:0]  pins_s;
  logic              wr_en;
  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [CODE_W-1:0] wr_data;
  logic              sd_all_n;
  logic              sd_one_n;

  qdac_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_IDLE)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({shdn_req_n, load_n, clear_n, ser_din, ser_cs_n, ser_clk}),
    .q   (pins_s)
  );

  qdac_frame_shifter #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .s_clk    (pins_s[0]),
    .s_cs_n   (pins_s[1]),
    .s_din    (pins_s[2]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sd_all_n (sd_all_n),
    .sd_one_n (sd_one_n)
  );

  // clear blocks the whole word, power-down bits included
  assign wr_go = wr_en & pins_s[3];

  qdac_chan_bank #(.CH_NUM(CH_NUM), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) i_bank (
    .clk      (clk),
    .rst      (rst),
    .clear_n  (pins_s[3]),
    .load_n   (pins_s[4]),
    .wr_en    (wr_go),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dac_flat (dac_codes)
  );

  qdac_shdn_ctrl #(.CH_NUM(CH_NUM), .ADDR_W(ADDR_W)) i_shdn (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_go),
    .wr_addr  (wr_addr),
    .sd_all_n (sd_all_n),
    .sd_one_n (sd_one_n),
    .ext_n    (pins_s[5]),
    .chan_off (chan_off)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (dac_codes == '0 && chan_off == '0));

endmodule

// File: tb/test_qdac_front.sv
module test_qdac_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_cs_n = 1'b1;
  logic        ser_din = 1'b0;
  logic        load_n = 1'b1;
  logic        clear_n = 1'b1;
  logic        shdn_req_n = 1'b1;
  logic [31:0] dac_codes;
  logic [3:0]  chan_off;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [11:0] m_sr = '0;
  logic [7:0]  m_in  [4];
  logic [7:0]  m_dac [4];
  logic        m_glob = 1'b0;
  logic [3:0]  m_ch   = '0;

  always #2 clk = ~clk;

  qdac_front i_qdac_front (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n),
    .shdn_req_n(shdn_req_n), .dac_codes(dac_codes), .chan_off(chan_off)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] exp_off();
    return {4{m_glob | ~shdn_req_n}} | m_ch;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 4; c++)
      check(tag, 32'(dac_codes[8*c +: 8]), 32'(m_dac[c]));
    check({tag, " off"}, 32'(chan_off), 32'(exp_off()));
  endtask

  // model of a word latched at the rising edge of select
  task automatic model_latch();
    logic [1:0] a;
    a = m_sr[9:8];
    if (clear_n) begin
      m_in[a] = m_sr[7:0];
      case ({m_sr[11], m_sr[10]})
        2'b11: begin m_glob = 1'b0; m_ch[a] = 1'b0; end
        2'b10: m_ch[a] = 1'b1;
        2'b01: m_glob = 1'b1;
        default: begin m_glob = 1'b1; m_ch[a] = 1'b1; end
      endcase
      if (!load_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    ser_cs_n = 1'b0;
    wait_clk(4);
    for (int k = n - 1; k >= 0; k--) begin
      ser_din = w[k];
      wait_clk(4);
      ser_clk = 1'b1;
      m_sr = {m_sr[10:0], w[k]};
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    ser_cs_n = 1'b1;
    model_latch();
    wait_clk(10);
  endtask

  task automatic idle_clocks(input logic [15:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      ser_din = w[k];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(4);
    load_n = 1'b1;
    if (clear_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    wait_clk(8);
  endtask

  task automatic pulse_clear();
    clear_n = 1'b0;
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    wait_clk(8);
    clear_n = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [15:0] word(input logic an, input logic on,
                                       input logic [1:0] a, input logic [7:0] d);
    return {4'b0000, an, on, a, d};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    wait_clk(6);
    rst = 1'b0;
    wait_clk(4);
    check_all("R1 reset");

    // R4 / R5: stage all channels with load high, outputs must hold
    send(word(1, 1, 2'd0, 8'h11), 12);
    send(word(1, 1, 2'd1, 8'h22), 12);
    send(word(1, 1, 2'd2, 8'h33), 12);
    send(word(1, 1, 2'd3, 8'h44), 12);
    check_all("R5 hold before load");
    pulse_load();
    check_all("R4 R2 address map after load");

    // R6: load held low is transparent
    load_n = 1'b0;
    wait_clk(8);
    send(word(1, 1, 2'd2, 8'hC5), 12);
    check_all("R6 transparent load");
    load_n = 1'b1;
    wait_clk(8);

    // R12: longer and shorter words
    send(16'hE000 | word(1, 1, 2'd1, 8'h9A), 15);
    send(word(1, 1, 2'd3, 8'h5E), 12);
    send(16'h0007, 5);
    pulse_load();
    check_all("R12 odd word lengths");

    // R3: clocks while select high must not move the shift register
    send(word(1, 1, 2'd0, 8'h5A), 12);
    ser_cs_n = 1'b1;
    idle_clocks(word(1, 1, 2'd0, 8'hFF), 12);
    send(16'h0, 0);
    pulse_load();
    check_all("R3 clocks ignored while select high");

    // R9 / R10 / R8 / R11
    send(word(1, 0, 2'd2, 8'h10), 12);
    check_all("R9 single channel off");
    send(word(0, 1, 2'd1, 8'h20), 12);
    check_all("R8 all channels off");
    send(word(1, 1, 2'd3, 8'h30), 12);
    check_all("R10 resume addressed and global");
    shdn_req_n = 1'b0;
    wait_clk(8);
    check_all("R11 external request");
    shdn_req_n = 1'b1;
    wait_clk(8);
    check_all("R11 release restores");
    send(word(1, 1, 2'd2, 8'h40), 12);
    check_all("R10 resume channel 2");

    // R7 / R13: clear with word and load during clear
    pulse_load();
    clear_n = 1'b0;
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    wait_clk(8);
    load_n = 1'b0;
    send(word(0, 0, 2'd1, 8'hAB), 12);
    check_all("R7 R13 clear dominates word and load");
    load_n = 1'b1;
    clear_n = 1'b1;
    wait_clk(8);
    pulse_load();
    check_all("R7 ranks zero after clear");

    // random phase
    for (int it = 0; it < 200; it++) begin
      logic [15:0] w;
      int extra;
      w = 16'($urandom);
      w[11] = ($urandom % 8) != 0;
      w[10] = ($urandom % 6) != 0;
      extra = int'($urandom % 4);
      if (($urandom % 2) == 1) begin
        load_n = 1'b0;
        wait_clk(6);
        send(w, 12 + extra);
        load_n = 1'b1;
        wait_clk(6);
      end else begin
        send(w, 12 + extra);
        if (($urandom % 2) == 1) pulse_load();
      end
      if (($urandom % 16) == 0) pulse_clear();
      check_all("R2 R4 R5 R12 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule